// File: doc/BRIEF.md
# Bidirectional GPIO Port with Emulation Passthrough

This block controls a bank of general-purpose pins from a simple memory-mapped bus. There are two local registers. The output-value register holds the level each pin drives. The direction register decides, bit by bit, whether a pin drives or floats. Pin inputs reach the read path through a multi-flop synchronizer clocked by the bus clock. A read of the output-value register returns a per-bit mix: driven pins return the latched value, and floating pins return the synchronized pin level.

When the emulation input is high, reads of either register come from an external-bus data input instead of local state. Writes still update the local registers. Each write is also copied to the external bus as a single-cycle strobe that carries the address and the data. Reads are combinational from the address. Writes take effect on the rising clock edge where the write enable is sampled high.

Top module: `gpio_emu_port`

## Requirements
- R1: After the active-low asynchronous reset, both registers hold zero. `pin_oe_o` and `pin_o` are all zero, and a direction read returns zero.
- R2: Each bit of `pin_oe_o` equals the matching direction register bit, where 1 means the pin drives and 0 means it floats. The new value shows from the clock edge that performs the write.
- R3: Each bit of `pin_o` equals the matching output-value register bit, whatever the direction.
- R4: The direction register sits at offset 1. It can be written and read back at any time.
- R5: The output-value register sits at offset 0. Outside emulation, a read returns the latched bit where the direction bit is 1 and the synchronized pin where it is 0.
- R6: A pin change reaches the offset-0 read after exactly two rising clock edges. It does not show after one.
- R7: With emulation high, reads at offsets 0 and 1 return `ext_rdata_i`.
- R8: With emulation high, writes still update the local registers. `pin_o` and `pin_oe_o` follow them.
- R9: With emulation high, every write drives `ext_wr_o` high for exactly the one cycle after the write edge. In that cycle `ext_addr_o` and `ext_wdata_o` carry the write's address and data. Outside emulation, `ext_wr_o` stays low.
- R10: Offsets other than 0 and 1 read as zero, with or without emulation. Writes to them change no local register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| emu_i | input | 1 | Emulation mode select |
| bus_addr_i | input | ADDR_W | Register offset for reads and writes |
| bus_wr_i | input | 1 | Write enable, sampled on the rising edge |
| bus_wdata_i | input | WIDTH | Write data |
| bus_rdata_o | output | WIDTH | Read data, combinational from the address |
| ext_rdata_i | input | WIDTH | External-bus read data used in emulation |
| ext_wr_o | output | 1 | External write strobe |
| ext_addr_o | output | ADDR_W | External write address |
| ext_wdata_o | output | WIDTH | External write data |
| pin_i | input | WIDTH | Pin levels from the pads |
| pin_o | output | WIDTH | Pin drive values |
| pin_oe_o | output | WIDTH | Pin output enables |

## Verification
A bad direction bit shows on `pin_oe_o` and in the offset-1 read on the cycle right after the write. It also selects the wrong source for that bit of the offset-0 read. A bad output-value bit shows on `pin_o` at once. Synchronizer faults show as a pin change that reaches the read one edge early or late, so reads are sampled after each edge. Faults in the emulation mirror show as a missing, doubled or misaddressed strobe in the single cycle after the write.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned OFS_DATA = 0;
  localparam int unsigned OFS_DIR  = 1;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[0] <= '0;
        else         stage_q[0] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  reg_sel_e         sel_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] data_q_o,
  output logic [WIDTH-1:0] dir_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q_o <= '0;
      dir_q_o  <= '0;
    end else if (wr_i) begin
      if (sel_i == SEL_DATA) data_q_o <= wdata_i;
      if (sel_i == SEL_DIR)  dir_q_o  <= wdata_i;
    end
  end

  AST_DATA_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_DATA) |=> data_q_o == $past(wdata_i)); // R3
  AST_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_DIR) |=> dir_q_o == $past(wdata_i)); // R4
  AST_BAD_OFS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_NONE) |=> ($stable(data_q_o) && $stable(dir_q_o))); // R10
endmodule

// File: rtl/gpio_ext_mirror.sv
module gpio_ext_mirror #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              emu_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic              ext_wr_o,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic [WIDTH-1:0]  ext_wdata_o
);
  logic fire;
  assign fire = emu_i & wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_wr_o    <= 1'b0;
      ext_addr_o  <= '0;
      ext_wdata_o <= '0;
    end else begin
      ext_wr_o <= fire;
      if (fire) begin
        ext_addr_o  <= addr_i;
        ext_wdata_o <= wdata_i;
      end
    end
  end

  AST_EXT_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> (ext_wr_o && ext_wdata_o == $past(wdata_i) && ext_addr_o == $past(addr_i))); // R9
  AST_NO_STROBE_OUTSIDE_EMU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> !ext_wr_o); // R9
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             emu_i,
  input  reg_sel_e         sel_i,
  input  logic [WIDTH-1:0] data_q_i,
  input  logic [WIDTH-1:0] dir_q_i,
  input  logic [WIDTH-1:0] pin_sync_i,
  input  logic [WIDTH-1:0] ext_rdata_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] data_view;

  // per-bit source: driven pins read the latch, floating pins read the pad
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign data_view[b] = dir_q_i[b] ? data_q_i[b] : pin_sync_i[b];
  end

  always_comb begin
    unique case (sel_i)
      SEL_DATA: rdata_o = emu_i ? ext_rdata_i : data_view;
      SEL_DIR:  rdata_o = emu_i ? ext_rdata_i : dir_q_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_emu_port.sv
module gpio_emu_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              emu_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [WIDTH-1:0]  bus_wdata_i,
  output logic [WIDTH-1:0]  bus_rdata_o,
  input  logic [WIDTH-1:0]  ext_rdata_i,
  output logic              ext_wr_o,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic [WIDTH-1:0]  ext_wdata_o,
  input  logic [WIDTH-1:0]  pin_i,
  output logic [WIDTH-1:0]  pin_o,
  output logic [WIDTH-1:0]  pin_oe_o
);
  localparam logic [ADDR_W-1:0] AddrData = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] AddrDir  = ADDR_W'(OFS_DIR);

  reg_sel_e         sel;
  logic [WIDTH-1:0] data_q, dir_q, pin_sync;

  always_comb begin
    if (bus_addr_i == AddrData)     sel = SEL_DATA;
    else if (bus_addr_i == AddrDir) sel = SEL_DIR;
    else                            sel = SEL_NONE;
  end

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (bus_wr_i),
    .sel_i    (sel),
    .wdata_i  (bus_wdata_i),
    .data_q_o (data_q),
    .dir_q_o  (dir_q)
  );

  gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pin_i),
    .sync_o  (pin_sync)
  );

  gpio_read_mux #(.WIDTH(WIDTH)) u_rmux (
    .emu_i       (emu_i),
    .sel_i       (sel),
    .data_q_i    (data_q),
    .dir_q_i     (dir_q),
    .pin_sync_i  (pin_sync),
    .ext_rdata_i (ext_rdata_i),
    .rdata_o     (bus_rdata_o)
  );

  gpio_ext_mirror #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_mirror (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .emu_i       (emu_i),
    .wr_i        (bus_wr_i),
    .addr_i      (bus_addr_i),
    .wdata_i     (bus_wdata_i),
    .ext_wr_o    (ext_wr_o),
    .ext_addr_o  (ext_addr_o),
    .ext_wdata_o (ext_wdata_o)
  );

  assign pin_o    = data_q;
  assign pin_oe_o = dir_q;

  AST_OE_MATCHES_DIR_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!emu_i && bus_addr_i == AddrDir) |-> bus_rdata_o == pin_oe_o); // R2
  AST_EMU_WRITE_LOCAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emu_i && bus_wr_i && bus_addr_i == AddrDir) |=> pin_oe_o == $past(bus_wdata_i)); // R8
endmodule

// File: tb/tb_gpio_emu_port.sv
module tb_gpio_emu_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       emu = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] ext_rdata = '0;
  logic       ext_wr;
  logic [1:0] ext_addr;
  logic [7:0] ext_wdata;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_oe;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_emu_port dut (
    .clk_i(clk), .rst_ni(rst_n), .emu_i(emu), .bus_addr_i(addr),
    .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .ext_rdata_i(ext_rdata), .ext_wr_o(ext_wr), .ext_addr_o(ext_addr),
    .ext_wdata_o(ext_wdata), .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe)
  );

  typedef struct packed {
    logic       emu;
    logic       wr;
    logic [1:0] waddr;
    logic [7:0] wdata;
    logic [1:0] raddr;
    logic [7:0] pin;
    logic [7:0] ext;
    logic [7:0] exp_rd;
    logic [7:0] exp_po;
    logic [7:0] exp_oe;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 2'd1, 8'hF0, 2'd1, 8'h00, 8'h00, 8'hF0, 8'h00, 8'hF0, 8'd4},  // R4 R2 dir write/read
    '{1'b0, 1'b1, 2'd0, 8'hA5, 2'd0, 8'h0F, 8'h00, 8'hAF, 8'hA5, 8'hF0, 8'd5},  // R5 R3 mixed read
    '{1'b0, 1'b0, 2'd0, 8'h00, 2'd0, 8'h3C, 8'h00, 8'hAC, 8'hA5, 8'hF0, 8'd5},  // R5 new pins
    '{1'b0, 1'b1, 2'd2, 8'hFF, 2'd2, 8'h3C, 8'h00, 8'h00, 8'hA5, 8'hF0, 8'd10}, // R10 offset 2
    '{1'b0, 1'b1, 2'd3, 8'h00, 2'd0, 8'h3C, 8'h00, 8'hAC, 8'hA5, 8'hF0, 8'd10}, // R10 offset 3 write
    '{1'b1, 1'b1, 2'd1, 8'h0F, 2'd1, 8'h3C, 8'h5A, 8'h5A, 8'hA5, 8'h0F, 8'd8},  // R8 R7 emu dir
    '{1'b1, 1'b0, 2'd0, 8'h00, 2'd0, 8'h3C, 8'hC3, 8'hC3, 8'hA5, 8'h0F, 8'd7},  // R7 emu data
    '{1'b1, 1'b0, 2'd0, 8'h00, 2'd2, 8'h3C, 8'hFF, 8'h00, 8'hA5, 8'h0F, 8'd10}, // R10 emu offset 2
    '{1'b0, 1'b0, 2'd0, 8'h00, 2'd0, 8'h3C, 8'hFF, 8'h35, 8'hA5, 8'h0F, 8'd5},  // R5 after emu dir
    '{1'b0, 1'b1, 2'd0, 8'h00, 2'd0, 8'h3C, 8'h00, 8'h30, 8'h00, 8'h0F, 8'd3}   // R3 data clear
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 oe", pin_oe, 8'h00);
    chk("R1 pin_o", pin_out, 8'h00);
    rst_n = 1'b1;
    tick();
    addr = 2'd1;
    #1 chk("R1 dir read", rdata, 8'h00);

    foreach (VECS[i]) begin
      emu = VECS[i].emu; pin_in = VECS[i].pin; ext_rdata = VECS[i].ext;
      wr = VECS[i].wr; addr = VECS[i].waddr; wdata = VECS[i].wdata;
      tick();
      wr = 1'b0; addr = VECS[i].raddr;
      tick();
      tick();
      chk($sformatf("R%0d vec%0d rd", VECS[i].req, i), rdata, VECS[i].exp_rd);
      chk($sformatf("R%0d vec%0d po", VECS[i].req, i), pin_out, VECS[i].exp_po);
      chk($sformatf("R%0d vec%0d oe", VECS[i].req, i), pin_oe, VECS[i].exp_oe);
    end

    // R6 synchronizer latency: all pins inputs
    emu = 1'b0; wr = 1'b1; addr = 2'd1; wdata = 8'h00;
    tick();
    wr = 1'b0; addr = 2'd0; pin_in = 8'h00;
    tick(); tick(); tick();
    chk("R6 settled", rdata, 8'h00);
    pin_in = 8'hFF;
    tick();
    chk("R6 one edge", rdata, 8'h00);
    tick();
    chk("R6 two edges", rdata, 8'hFF);

    // R9 emulation write strobe
    emu = 1'b1; wr = 1'b1; addr = 2'd1; wdata = 8'h77;
    chk("R9 before edge", {7'd0, ext_wr}, 8'h00);
    tick();
    wr = 1'b0;
    chk("R9 strobe", {7'd0, ext_wr}, 8'h01);
    chk("R9 addr", {6'd0, ext_addr}, 8'h01);
    chk("R9 wdata", ext_wdata, 8'h77);
    chk("R8 oe local", pin_oe, 8'h77);
    tick();
    chk("R9 strobe width", {7'd0, ext_wr}, 8'h00);
    // R9 no strobe outside emulation
    emu = 1'b0; wr = 1'b1; addr = 2'd0; wdata = 8'h11;
    tick();
    wr = 1'b0;
    chk("R9 no strobe", {7'd0, ext_wr}, 8'h00);
    chk("R3 pin_o", pin_out, 8'h11);

    // R1 reset mid-run
    rst_n = 1'b0;
    #1;
    chk("R1 async oe", pin_oe, 8'h00);
    chk("R1 async pin_o", pin_out, 8'h00);
    tick();
    rst_n = 1'b1;
    tick();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule